// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small processor built around one accumulator. It runs every instruction as a sequence of register-transfer micro-steps, one per clock. The steps are: fetch the word at the program counter, decode its opcode, then execute. All traffic to the single word-addressed memory passes through an address register and a data register. The address register drives the memory address output. Reads land in the data register, and the data register supplies the write data.

The core supports these direct-addressed operations: load, add, store, compare, branch-if-zero, unconditional jump and halt. Add and compare update a four-bit status register. Branch-if-zero tests the zero bit. During fetch the program counter is always advanced to the next word. A taken branch later replaces that value with its target. The architectural counter, accumulator and flags are brought out as plain outputs so that the surrounding logic can observe them.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, accumulator and flags, drops both memory strobes and `halted`, and the first clock after release starts a fetch at address 0.
- R2: Fetch takes five clocks in this order: address register ← PC, read strobe, data register ← memory word, instruction register ← data register, PC ← PC + 1. A decode clock follows. Load, add and compare then take 4 execute clocks, store takes 2, and branch and jump take 1. Each read strobe lasts exactly one clock, and the word is taken one clock later.
- R3: An instruction word is 16 bits. Bits 15:8 hold the opcode: 0x01 load, 0x02 add, 0x03 store, 0x04 compare, 0x05 branch-if-zero, 0x06 jump, 0xFF halt. Bits 7:0 hold the direct operand address.
- R4: Load reads the word at the operand address into the accumulator.
- R5: Add writes accumulator + word into the accumulator. It sets `flags_o` as follows: bit0 Z (result is 0), bit1 N (result bit 15), bit2 C (unsigned carry out) and bit3 V (signed overflow).
- R6: Store raises the write strobe for one clock. During that clock the address is the operand and the write data is the accumulator.
- R7: Compare computes accumulator − word. It sets Z and N from the difference, C on an unsigned borrow and V on a signed overflow, and it leaves the accumulator unchanged.
- R8: Branch-if-zero sets the program counter to the operand when Z is 1. Otherwise execution continues at the incremented address.
- R9: Jump always sets the program counter to the operand.
- R10: Load, store, branch-if-zero and jump leave the flags unchanged.
- R11: Halt stops the sequencer and holds `halted` high, with no memory strobe and a frozen program counter, until reset.
- R12: Any other opcode executes as a no-op, and the next fetch follows directly after decode.
- R13: The read and write strobes are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data is expected one clock later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data from the synchronous memory |
| halted | output | 1 | High once a halt instruction has executed |
| pc_o | output | 8 | Program counter |
| acc_o | output | 16 | Accumulator |
| flags_o | output | 4 | Flags {V, C, N, Z} |

## Verification
The bench builds the core with its default widths: 16-bit data, 8-bit opcodes and 8-bit addresses. With 16-bit data, the sign and carry boundaries at 0x7FFF, 0x8000 and 0xFFFF can be reached directly with add and compare operands. With 8-bit addresses, the bench can model the whole 256-word memory as a plain array. That array serves as the memory, so stores are checked in memory words, and the exact number of clocks and read strobes per instruction can be counted.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam logic [7:0] OP_LOAD  = 8'h01;
  localparam logic [7:0] OP_ADD   = 8'h02;
  localparam logic [7:0] OP_STORE = 8'h03;
  localparam logic [7:0] OP_CMP   = 8'h04;
  localparam logic [7:0] OP_BRZ   = 8'h05;
  localparam logic [7:0] OP_JMP   = 8'h06;
  localparam logic [7:0] OP_HALT  = 8'hFF;

  typedef enum logic [3:0] {
    ST_F_ADDR, ST_F_READ, ST_F_CAP, ST_F_IR, ST_F_INC, ST_DECODE,
    ST_X_ADDR, ST_X_READ, ST_X_CAP, ST_X_ALU, ST_X_WRITE, ST_X_BR,
    ST_HALT
  } step_t;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] wide_sum(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b,
                                               input logic sub);
    if (sub) return {1'b0, a} - {1'b0, b};
    else     return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic signed_ovf(input logic a_s, input logic b_s,
                                      input logic r_s, input logic sub);
    if (sub) return (a_s != b_s) && (r_s != a_s);
    else     return (a_s == b_s) && (r_s != a_s);
  endfunction

  logic [DATA_W:0] wide;

  always_comb begin
    wide      = wide_sum(a_i, b_i, sub_i);
    res_o     = wide[MSB:0];
    flags_o.z = (wide[MSB:0] == '0);
    flags_o.n = wide[MSB];
    flags_o.c = wide[DATA_W];
    flags_o.v = signed_ovf(a_i[MSB], b_i[MSB], wide[MSB], sub_i);
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode_i,
  output step_t            step_o
);
  step_t step_q, step_d;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_F_ADDR: step_d = ST_F_READ;
      ST_F_READ: step_d = ST_F_CAP;
      ST_F_CAP:  step_d = ST_F_IR;
      ST_F_IR:   step_d = ST_F_INC;
      ST_F_INC:  step_d = ST_DECODE;
      ST_DECODE: begin
        if (opcode_i == OPC_W'(OP_LOAD) || opcode_i == OPC_W'(OP_ADD) ||
            opcode_i == OPC_W'(OP_CMP)  || opcode_i == OPC_W'(OP_STORE))
          step_d = ST_X_ADDR;
        else if (opcode_i == OPC_W'(OP_BRZ) || opcode_i == OPC_W'(OP_JMP))
          step_d = ST_X_BR;
        else if (opcode_i == OPC_W'(OP_HALT))
          step_d = ST_HALT;
        else
          step_d = ST_F_ADDR;
      end
      ST_X_ADDR:  step_d = (opcode_i == OPC_W'(OP_STORE)) ? ST_X_WRITE : ST_X_READ;
      ST_X_READ:  step_d = ST_X_CAP;
      ST_X_CAP:   step_d = ST_X_ALU;
      ST_X_ALU:   step_d = ST_F_ADDR;
      ST_X_WRITE: step_d = ST_F_ADDR;
      ST_X_BR:    step_d = ST_F_ADDR;
      ST_HALT:    step_d = ST_HALT;
      default:    step_d = ST_F_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_F_ADDR;
    else     step_q <= step_d;
  end

  assign step_o = step_q;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OPC_W  = 8,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [3:0]        flags_o
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, cir_q, acc_q;
  flags_t            flags_q;
  step_t             step;

  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] operand;
  logic              is_add, is_cmp, is_load, is_store, is_brz, is_jmp;

  assign opcode   = cir_q[DATA_W-1 -: OPC_W];
  assign operand  = cir_q[ADDR_W-1:0];
  assign is_load  = (opcode == OPC_W'(OP_LOAD));
  assign is_add   = (opcode == OPC_W'(OP_ADD));
  assign is_store = (opcode == OPC_W'(OP_STORE));
  assign is_cmp   = (opcode == OPC_W'(OP_CMP));
  assign is_brz   = (opcode == OPC_W'(OP_BRZ));
  assign is_jmp   = (opcode == OPC_W'(OP_JMP));

  acc_seq #(.OPC_W(OPC_W)) u_seq (
    .clk(clk), .rst(rst), .opcode_i(opcode), .step_o(step)
  );

  logic [DATA_W-1:0] alu_res;
  flags_t            alu_flags;

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i(acc_q), .b_i(mdr_q), .sub_i(is_cmp),
    .res_o(alu_res), .flags_o(alu_flags)
  );

  // Named internal events, used by the bound checker.
  logic              evt_pc_inc, evt_flag_we, evt_br_take;
  logic [ADDR_W-1:0] br_target;
  assign evt_pc_inc  = (step == ST_F_INC);
  assign evt_flag_we = (step == ST_X_ALU) && (is_add || is_cmp);
  assign evt_br_take = (step == ST_X_BR) && (is_jmp || (is_brz && flags_q.z));
  assign br_target   = operand;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      cir_q   <= '0;
      acc_q   <= '0;
      flags_q <= '0;
    end else begin
      unique case (step)
        ST_F_ADDR: mar_q <= pc_q;
        ST_F_CAP:  mdr_q <= mem_rdata;
        ST_F_IR:   cir_q <= mdr_q;
        ST_F_INC:  pc_q  <= pc_q + 1'b1;
        ST_X_ADDR: begin
          mar_q <= operand;
          if (is_store) mdr_q <= acc_q;
        end
        ST_X_CAP:  mdr_q <= mem_rdata;
        ST_X_ALU: begin
          if (is_load) acc_q <= mdr_q;
          if (is_add)  acc_q <= alu_res;
          if (evt_flag_we) flags_q <= alu_flags;
        end
        ST_X_BR:   if (evt_br_take) pc_q <= br_target;
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_rd    = (step == ST_F_READ) || (step == ST_X_READ);
  assign mem_wr    = (step == ST_X_WRITE);
  assign halted    = (step == ST_HALT);
  assign pc_o      = pc_q;
  assign acc_o     = acc_q;
  assign flags_o   = flags_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] acc_o,
  input logic              halted,
  input logic [ADDR_W-1:0] pc_o,
  input logic [3:0]        flags_o,
  input logic              evt_pc_inc,
  input logic              evt_flag_we,
  input logic              evt_br_take,
  input logic [ADDR_W-1:0] br_target
);
  assert_rd_single_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    evt_pc_inc |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  assert_store_data_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_wdata == acc_o);

  assert_branch_target_R8: assert property (@(posedge clk) disable iff (rst)
    evt_br_take |=> pc_o == $past(br_target));

  assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !evt_flag_we |=> $stable(flags_o));

  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc_o) && !mem_rd && !mem_wr);

  assert_rw_exclusive_R13: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .acc_o(acc_o), .halted(halted), .pc_o(pc_o),
  .flags_o(flags_o), .evt_pc_inc(evt_pc_inc), .evt_flag_we(evt_flag_we),
  .evt_br_take(evt_br_take), .br_target(br_target)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr, pc_o;
  logic          mem_rd, mem_wr, halted;
  logic [DW-1:0] mem_wdata, acc_o;
  logic [DW-1:0] mem_rdata = '0;
  logic [3:0]    flags_o;
  logic [DW-1:0] mem [DEPTH];

  int checks = 0;
  int errors = 0;
  int cyc, rdn, wrn;

  always #10 clk = ~clk;

  acc_core #(.ADDR_W(AW), .OPC_W(8)) u_acc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .pc_o(pc_o), .acc_o(acc_o), .flags_o(flags_o)
  );

  // Synchronous memory, one cycle read latency.
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [DW-1:0] ins(input logic [7:0] op, input logic [7:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    @(negedge clk);
  endtask

  task automatic run(input int limit);
    cyc = 0; rdn = 0; wrn = 0;
    rst = 1'b0;
    while (!halted && cyc < limit) begin
      cyc++;
      if (mem_rd) rdn++;
      if (mem_wr) wrn++;
      @(negedge clk);
    end
    if (!halted) chk("R11", "halt reached", 0, 1);
  endtask

  task automatic t_reset();
    hold_reset();
    chk("R1", "pc", pc_o, 0);
    chk("R1", "acc", acc_o, 0);
    chk("R1", "flags", flags_o, 0);
    chk("R1", "strobes", {halted, mem_rd, mem_wr}, 0);
  endtask

  task automatic t_trace();
    hold_reset();
    mem[0] <= ins(8'h01, 8'd20); mem[1] <= ins(8'h02, 8'd21);
    mem[2] <= ins(8'h03, 8'd22); mem[3] <= ins(8'hFF, 8'd0);
    mem[20] <= 16'd14; mem[21] <= 16'd9;
    @(negedge clk);
    run(200);
    chk("R6", "stored sum", mem[22], 23);
    chk("R4", "acc", acc_o, 23);
    chk("R5", "flags", flags_o, 0);
    chk("R2", "cycles load+add+store+halt", cyc, 10 + 10 + 8 + 6);
    chk("R6", "write strobes", wrn, 1);
    // Reset after a run clears state.
    t_reset();
  endtask

  task automatic t_timing();
    hold_reset();
    mem[0] <= ins(8'h01, 8'd20); mem[1] <= ins(8'hFF, 8'd0);
    mem[20] <= 16'h1234;
    @(negedge clk);
    run(200);
    chk("R2", "cycles load+halt", cyc, 16);
    chk("R2", "read strobes", rdn, 3);
    chk("R4", "acc", acc_o, 16'h1234);
    chk("R11", "pc after halt", pc_o, 2);
  endtask

  task automatic t_add_flags(input logic [DW-1:0] a, input logic [DW-1:0] b,
                             input logic [DW-1:0] sum, input logic [3:0] fl);
    hold_reset();
    mem[0] <= ins(8'h01, 8'd20); mem[1] <= ins(8'h02, 8'd21);
    mem[2] <= ins(8'hFF, 8'd0);
    mem[20] <= a; mem[21] <= b;
    @(negedge clk);
    run(200);
    chk("R5", "add result", acc_o, sum);
    chk("R5", "add flags", flags_o, fl);
  endtask

  task automatic t_cmp(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [3:0] fl);
    hold_reset();
    mem[0] <= ins(8'h01, 8'd20); mem[1] <= ins(8'h04, 8'd21);
    mem[2] <= ins(8'hFF, 8'd0);
    mem[20] <= a; mem[21] <= b;
    @(negedge clk);
    run(200);
    chk("R7", "acc kept", acc_o, a);
    chk("R7", "cmp flags", flags_o, fl);
  endtask

  task automatic t_brz(input logic [DW-1:0] b, input bit taken);
    hold_reset();
    mem[0] <= ins(8'h01, 8'd20); mem[1] <= ins(8'h04, 8'd21);
    mem[2] <= ins(8'h05, 8'd5);  mem[3] <= ins(8'h03, 8'd30);
    mem[4] <= ins(8'hFF, 8'd0);  mem[5] <= ins(8'h03, 8'd31);
    mem[6] <= ins(8'hFF, 8'd0);
    mem[20] <= 16'd5; mem[21] <= b;
    mem[30] <= 16'hDEAD; mem[31] <= 16'hBEEF;
    @(negedge clk);
    run(300);
    chk("R8", "taken path store", mem[31], taken ? 16'd5 : 16'hBEEF);
    chk("R8", "fallthrough store", mem[30], taken ? 16'hDEAD : 16'd5);
    chk("R8", "final pc", pc_o, taken ? 7 : 5);
  endtask

  task automatic t_jmp_flags();
    hold_reset();
    mem[0] <= ins(8'h01, 8'd20); mem[1] <= ins(8'h04, 8'd20);
    mem[2] <= ins(8'h01, 8'd21); mem[3] <= ins(8'h03, 8'd32);
    mem[4] <= ins(8'h06, 8'd7);  mem[5] <= ins(8'h03, 8'd30);
    mem[6] <= ins(8'hFF, 8'd0);  mem[7] <= ins(8'h05, 8'd9);
    mem[8] <= ins(8'hFF, 8'd0);  mem[9] <= ins(8'hFF, 8'd0);
    mem[20] <= 16'd5; mem[21] <= 16'h8000; mem[30] <= 16'hDEAD;
    @(negedge clk);
    run(400);
    chk("R9", "skipped store", mem[30], 16'hDEAD);
    chk("R10", "flags kept Z after load/store/jmp", flags_o, 4'h1);
    chk("R10", "brz still sees Z, pc", pc_o, 10);
    chk("R6", "store of loaded value", mem[32], 16'h8000);
  endtask

  task automatic t_halt_hold();
    hold_reset();
    mem[0] <= ins(8'hFF, 8'd0);
    @(negedge clk);
    run(50);
    rdn = 0; wrn = 0;
    for (int i = 0; i < 20; i++) begin
      if (mem_rd) rdn++;
      if (mem_wr) wrn++;
      @(negedge clk);
    end
    chk("R11", "still halted", halted, 1);
    chk("R11", "pc frozen", pc_o, 1);
    chk("R11", "no strobes while halted", rdn + wrn, 0);
  endtask

  task automatic t_undefined();
    hold_reset();
    mem[0] <= ins(8'h77, 8'd20); mem[1] <= ins(8'h01, 8'd20);
    mem[2] <= ins(8'hFF, 8'd0);
    mem[20] <= 16'h0042;
    @(negedge clk);
    run(200);
    chk("R12", "acc after no-op", acc_o, 16'h0042);
    chk("R12", "cycles no-op+load+halt", cyc, 6 + 10 + 6);
    chk("R3", "pc", pc_o, 3);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_trace();
    t_timing();
    t_add_flags(16'h7FFF, 16'h0001, 16'h8000, 4'hA);
    t_add_flags(16'hFFFF, 16'h0001, 16'h0000, 4'h5);
    t_cmp(16'd5, 16'd5, 4'h1);
    t_cmp(16'd5, 16'd7, 4'h6);
    t_cmp(16'h8000, 16'h0001, 4'h8);
    t_brz(16'd5, 1'b1);
    t_brz(16'd6, 1'b0);
    t_jmp_flags();
    t_halt_hold();
    t_undefined();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule